// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache that sits between a processor request port and a lower-level memory port. Every byte address is split into three parts. The low part is the position inside a line. The middle part picks one of `NUM_SETS` sets, which is the line number modulo the set count. The upper part is kept as the tag. Each set holds two lines. Every line has a valid flag, a dirty flag and a tag, and each set has one recency bit that selects its replacement candidate.

The cache uses write-back and write-allocate. A hit is served from the local arrays and writes nothing to memory. A miss first empties the chosen victim line to memory, word by word, but only when that line is dirty. It then fetches the requested line, one word per beat, and finally completes the original read or write on the new line. The processor port accepts one request at a time and stays busy until that request has been answered.

Top module: `wb2w_cache`

## Requirements
- R1: In reset and in the first cycle after it, `cpu_req_ready` is 1 and `cpu_resp_valid` and `mem_req_valid` are 0. Every line comes out of reset invalid, so the first access to any line misses.
- R2: Address bits [BYTE_B-1:0] select a byte inside a word and are ignored. The word inside a line is the next `log2(LINE_WORDS)` bits. The set is the line number modulo `NUM_SETS`. The tag is all the remaining upper bits.
- R3: A request hits only if one way of its set is valid and holds a matching tag. A read hit raises `cpu_resp_valid` for one cycle, in the cycle after acceptance, with the stored word. `cpu_req_ready` returns to 1 in the following cycle.
- R4: A write hit changes only the addressed word and marks its line dirty. It causes no memory traffic and is acknowledged in the cycle after acceptance.
- R5: On a miss, `cpu_req_ready` stays 0 until the response. With a clean or invalid victim, the cache issues `LINE_WORDS` read beats for the missing line, at ascending word addresses from the line base. The response then comes `2*LINE_WORDS+2` cycles after acceptance, given a memory that is always ready and answers one cycle after each read.
- R6: A dirty victim is written to memory before the refill, as `LINE_WORDS` write beats carrying its own address and its current data, in ascending word order. Under the same memory timing, the response comes `3*LINE_WORDS+2` cycles after acceptance.
- R7: An invalid way is filled before any valid one. When both ways are valid, the least recently used way is replaced, and every hit and every fill updates the recency. With two sets and line numbers 0, 8, 0, 6, 8, the results are miss, miss, hit, miss, miss.
- R8: A write miss fetches the whole line and then writes the word into it, leaving the line dirty. A later read returns the written word, and the other words of the line keep their memory values.
- R9: A read miss returns the fetched word, and the line is left clean, so evicting it later produces no write beats.
- R10: A memory request holds its address and direction until `mem_req_ready` is 1. After a read beat is accepted, no new request is made until `mem_resp_valid` delivers its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word, valid with the pulse for reads |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_write | output | 1 | 1 = write-back beat, 0 = refill read |
| mem_req_addr | output | ADDR_W | Word-aligned beat address |
| mem_req_wdata | output | DATA_W | Write-back word |
| mem_resp_valid | input | 1 | Refill word present |
| mem_resp_rdata | input | DATA_W | Refill word |

## Verification
The bench builds the cache with two sets, two words per line, 16-bit addresses and 32-bit words. With only two sets, a short run of line numbers creates conflict, LRU eviction and dirty write-back many times over. It also lets the fixed sequence 0, 8, 0, 6, 8 fall into one set, as the replacement requirement expects. Two-word lines still exercise the multi-beat write-back and refill ordering, and the byte bits that are ignored. A pseudo-random mix of reads and writes over twelve lines then drives every path against a behavioural recency model.

// File: rtl/cwb_pkg.sv
// Shared types for the two-way write-back cache.
package cwb_pkg;
    // Controller states, in the order a miss walks through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_DONE
    } cstate_t;
endpackage

// File: rtl/cwb_meta.sv
// Per-line valid, dirty and tag storage for two ways, plus one recency bit per set.
// Assumes NUM_SETS is a power of two. Reads are combinational; updates happen at the clock edge.
module cwb_meta #(
    parameter int NUM_SETS = 4,
    parameter int IDX_B    = 2,
    parameter int TAG_B    = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_B-1:0]       idx,
    output logic [1:0]             vld_o,
    output logic [1:0]             dty_o,
    output logic [1:0][TAG_B-1:0]  tag_o,
    output logic                   lru_o,
    input  logic                   fill_en,
    input  logic                   fill_way,
    input  logic [TAG_B-1:0]       fill_tag,
    input  logic                   fill_dirty,
    input  logic                   mark_en,
    input  logic                   mark_way,
    input  logic                   touch_en,
    input  logic                   touch_way
);
    logic [NUM_SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [NUM_SETS-1:0] v_q;
        logic [NUM_SETS-1:0] d_q;
        logic [TAG_B-1:0]    t_q [NUM_SETS];

        // Valid and dirty flags: cleared by reset, set by fill or by a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
                d_q <= '0;
            end else if (fill_en && fill_way == 1'(w)) begin
                v_q[idx] <= 1'b1;
                d_q[idx] <= fill_dirty;
            end else if (mark_en && mark_way == 1'(w)) begin
                d_q[idx] <= 1'b1;
            end
        end

        // Tag storage: written only when a line is installed.
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) t_q[idx] <= fill_tag;
        end

        assign vld_o[w] = v_q[idx];
        assign dty_o[w] = d_q[idx];
        assign tag_o[w] = t_q[idx];
    end

    // Recency bit: points at the way not touched most recently.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru_q <= '0;
        else if (touch_en) lru_q[idx] <= ~touch_way;
    end

    assign lru_o = lru_q[idx];
endmodule

// File: rtl/cwb_data.sv
// Line data for both ways as a register array, one word per entry.
// Combinational read port and one synchronous write port. Contents are not reset.
module cwb_data #(
    parameter int DATA_W     = 32,
    parameter int NUM_SETS   = 4,
    parameter int LINE_WORDS = 4,
    parameter int IDX_B      = 2,
    parameter int WSEL_B     = 2
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [IDX_B-1:0]  rd_idx,
    input  logic [WSEL_B-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic              wr_way,
    input  logic [IDX_B-1:0]  wr_idx,
    input  logic [WSEL_B-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words_q [2][NUM_SETS][LINE_WORDS];

    // Word write port.
    always_ff @(posedge clk) begin
        if (we) words_q[wr_way][wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = words_q[rd_way][rd_idx][rd_word];
endmodule

// File: rtl/cwb_pick.sv
// Hit detection and victim choice for one two-way set.
// An invalid way is taken first (way 0 before way 1). Otherwise the recency bit decides.
module cwb_pick #(
    parameter int TAG_B = 10
) (
    input  logic [1:0]            vld,
    input  logic [1:0][TAG_B-1:0] tags,
    input  logic [TAG_B-1:0]      req_tag,
    input  logic                  lru,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  pick_way
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == req_tag);
    end

    assign hit      = |match;
    assign hit_way  = match[1];
    assign pick_way = !vld[0] ? 1'b0 : (!vld[1] ? 1'b1 : lru);
endmodule

// File: rtl/wb2w_cache.sv
// Two-way set-associative write-back, write-allocate data cache.
// Accepts one processor request at a time and answers it with a one-cycle response pulse.
// A miss writes back a dirty victim, refills the line one word per beat, then completes the request.
// Assumes LINE_WORDS >= 2 and NUM_SETS >= 2, both powers of two, and the memory port accepting
// one outstanding read at a time.
module wb2w_cache
    import cwb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    localparam int BYTE_B = $clog2(DATA_W / 8);
    localparam int WSEL_B = $clog2(LINE_WORDS);
    localparam int OFF_B  = BYTE_B + WSEL_B;
    localparam int IDX_B  = $clog2(NUM_SETS);
    localparam int TAG_B  = ADDR_W - OFF_B - IDX_B;
    localparam logic [WSEL_B-1:0] LAST_BEAT = WSEL_B'(LINE_WORDS - 1);

    cstate_t           state;
    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic              vway;
    logic [TAG_B-1:0]  vtag;
    logic [WSEL_B-1:0] beat;

    logic [TAG_B-1:0]  req_tag;
    logic [IDX_B-1:0]  req_idx;
    logic [WSEL_B-1:0] req_word;

    logic [1:0]            vld, dty;
    logic [1:0][TAG_B-1:0] tags;
    logic                  lru, hit, hit_way, pick_way;

    logic              rd_way;
    logic [WSEL_B-1:0] rd_word;
    logic [DATA_W-1:0] rd_data;
    logic              d_we, d_way;
    logic [WSEL_B-1:0] d_word;
    logic [DATA_W-1:0] d_wdata;

    logic in_lookup, in_done, last_beat;

    assign req_tag   = r_addr[ADDR_W-1 -: TAG_B];
    assign req_idx   = r_addr[OFF_B +: IDX_B];
    assign req_word  = r_addr[BYTE_B +: WSEL_B];
    assign in_lookup = (state == ST_LOOKUP);
    assign in_done   = (state == ST_DONE);
    assign last_beat = (beat == LAST_BEAT);

    cwb_meta #(.NUM_SETS(NUM_SETS), .IDX_B(IDX_B), .TAG_B(TAG_B)) u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .vld_o      (vld),
        .dty_o      (dty),
        .tag_o      (tags),
        .lru_o      (lru),
        .fill_en    (in_done),
        .fill_way   (vway),
        .fill_tag   (req_tag),
        .fill_dirty (r_write),
        .mark_en    (in_lookup && hit && r_write),
        .mark_way   (hit_way),
        .touch_en   ((in_lookup && hit) || in_done),
        .touch_way  (in_lookup ? hit_way : vway)
    );

    cwb_pick #(.TAG_B(TAG_B)) u_pick (
        .vld      (vld),
        .tags     (tags),
        .req_tag  (req_tag),
        .lru      (lru),
        .hit      (hit),
        .hit_way  (hit_way),
        .pick_way (pick_way)
    );

    cwb_data #(
        .DATA_W(DATA_W), .NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS),
        .IDX_B(IDX_B), .WSEL_B(WSEL_B)
    ) u_data (
        .clk     (clk),
        .rd_way  (rd_way),
        .rd_idx  (req_idx),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .we      (d_we),
        .wr_way  (d_way),
        .wr_idx  (req_idx),
        .wr_word (d_word),
        .wr_data (d_wdata)
    );

    // Controller: request capture, lookup, write-back, refill and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            vway    <= 1'b0;
            vtag    <= '0;
            beat    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cpu_req_valid) begin
                    r_write <= cpu_req_write;
                    r_addr  <= cpu_req_addr;
                    r_wdata <= cpu_req_wdata;
                    state   <= ST_LOOKUP;
                end
                ST_LOOKUP: if (hit) begin
                    state <= ST_IDLE;
                end else begin
                    vway  <= pick_way;
                    vtag  <= tags[pick_way];
                    beat  <= '0;
                    state <= (vld[pick_way] && dty[pick_way]) ? ST_WBACK : ST_FILL_REQ;
                end
                ST_WBACK: if (mem_req_ready) begin
                    beat <= last_beat ? '0 : beat + 1'b1;
                    if (last_beat) state <= ST_FILL_REQ;
                end
                ST_FILL_REQ: if (mem_req_ready) state <= ST_FILL_WAIT;
                ST_FILL_WAIT: if (mem_resp_valid) begin
                    beat  <= last_beat ? '0 : beat + 1'b1;
                    state <= last_beat ? ST_DONE : ST_FILL_REQ;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Data array write source: write hit, refill word, or write completing a miss.
    always_comb begin
        d_we    = 1'b0;
        d_way   = vway;
        d_word  = req_word;
        d_wdata = r_wdata;
        case (state)
            ST_LOOKUP: if (hit && r_write) begin
                d_we  = 1'b1;
                d_way = hit_way;
            end
            ST_FILL_WAIT: if (mem_resp_valid) begin
                d_we    = 1'b1;
                d_word  = beat;
                d_wdata = mem_resp_rdata;
            end
            ST_DONE: d_we = r_write;
            default: d_we = 1'b0;
        endcase
    end

    assign rd_way  = in_lookup ? hit_way : vway;
    assign rd_word = (state == ST_WBACK) ? beat : req_word;

    assign cpu_req_ready  = (state == ST_IDLE);
    assign cpu_resp_valid = (in_lookup && hit) || in_done;
    assign cpu_resp_rdata = rd_data;

    assign mem_req_valid = (state == ST_WBACK) || (state == ST_FILL_REQ);
    assign mem_req_write = (state == ST_WBACK);
    assign mem_req_addr  = {(state == ST_WBACK) ? vtag : req_tag, req_idx, beat, {BYTE_B{1'b0}}};
    assign mem_req_wdata = rd_data;
endmodule

// File: rtl/wb2w_cache_chk.sv
// Port-level protocol checks for wb2w_cache, attached with bind below.
module wb2w_cache_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (cpu_req_ready && !cpu_resp_valid && !mem_req_valid));

    // R3
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> (!cpu_resp_valid && cpu_req_ready));

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R5
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);
endmodule

bind wb2w_cache wb2w_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr)
);

// File: tb/sim_wb2w_cache.sv
// Bench: behavioural recency model and memory model, compared with the cache every cycle.
module sim_wb2w_cache;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 2;
    localparam int NS = 2;
    localparam int LINE_BYTES = LW * 4;
    localparam int LAT_HIT   = 1;
    localparam int LAT_CLEAN = 2 * LW + 2;
    localparam int LAT_DIRTY = 3 * LW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_resp_valid = 1'b0;
    logic [DW-1:0] mem_resp_rdata = '0;

    wb2w_cache #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .NUM_SETS(NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] lower [int];
    logic [DW-1:0] gold [int];
    bit            dirty_of [int];
    int front [NS];
    int back [NS];
    int exp_fill_blk = 0;
    int exp_wb_blk = 0;
    int rd_cnt = 0;
    int wb_cnt = 0;
    int seq [5] = '{0, 8, 0, 6, 8};
    bit seq_hit [5] = '{0, 0, 1, 0, 0};

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] initv(input int a);
        return 32'h9E37_0000 ^ (32'(a) * 32'h0000_1F3B);
    endfunction

    function automatic logic [DW-1:0] lower_rd(input int a);
        return lower.exists(a) ? lower[a] : initv(a);
    endfunction

    function automatic logic [DW-1:0] gold_rd(input int a);
        return gold.exists(a) ? gold[a] : initv(a);
    endfunction

    // Lower memory: always ready, answers a read one cycle later, checks beat order (R5, R6, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_resp_valid <= 1'b0;
        end else begin
            mem_resp_valid <= mem_req_valid && !mem_req_write;
            if (mem_req_valid && !mem_req_write) begin
                mem_resp_rdata <= lower_rd(int'(mem_req_addr) >> 2);
                chk(int'(mem_req_addr) == exp_fill_blk * LINE_BYTES + rd_cnt * 4, "R10",
                    32'(mem_req_addr), 32'(exp_fill_blk * LINE_BYTES + rd_cnt * 4));
                rd_cnt++;
            end
            if (mem_req_valid && mem_req_write) begin
                chk(int'(mem_req_addr) == exp_wb_blk * LINE_BYTES + wb_cnt * 4, "R6",
                    32'(mem_req_addr), 32'(exp_wb_blk * LINE_BYTES + wb_cnt * 4));
                chk(mem_req_wdata == gold_rd(int'(mem_req_addr) >> 2), "R6",
                    mem_req_wdata, gold_rd(int'(mem_req_addr) >> 2));
                lower[int'(mem_req_addr) >> 2] = mem_req_wdata;
                wb_cnt++;
            end
        end
    end

    // One request with model prediction and a cycle-by-cycle comparison until its response.
    task automatic access(input bit wr, input int addr, input logic [DW-1:0] wdata, output int obs_lat);
        int blk = addr / LINE_BYTES;
        int set = blk % NS;
        int waddr = addr / 4;
        bit hit;
        bit wbexp = 1'b0;
        int lat;
        logic [DW-1:0] exp_rd;
        hit = (front[set] == blk) || (back[set] == blk);
        if (hit) begin
            if (back[set] == blk) begin
                back[set]  = front[set];
                front[set] = blk;
            end
        end else begin
            if (front[set] < 0) begin
                front[set] = blk;
            end else if (back[set] < 0) begin
                back[set]  = front[set];
                front[set] = blk;
            end else begin
                exp_wb_blk = back[set];
                wbexp = dirty_of.exists(back[set]) && dirty_of[back[set]];
                dirty_of[back[set]] = 1'b0;
                back[set]  = front[set];
                front[set] = blk;
            end
            dirty_of[blk] = 1'b0;
        end
        if (wr) begin
            dirty_of[blk] = 1'b1;
            gold[waddr] = wdata;
        end
        exp_rd = gold_rd(waddr);
        lat = hit ? LAT_HIT : (wbexp ? LAT_DIRTY : LAT_CLEAN);
        exp_fill_blk = blk;
        @(negedge clk);
        chk(cpu_req_ready == 1'b1, "R3", 32'(cpu_req_ready), 32'd1);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = AW'(addr);
        cpu_req_wdata = wdata;
        rd_cnt = 0;
        wb_cnt = 0;
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        obs_lat = 0;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            chk(cpu_resp_valid == (k == lat), hit ? "R3" : "R5", 32'(cpu_resp_valid), 32'(k == lat));
            if (k < lat) chk(!cpu_req_ready, "R5", 32'(cpu_req_ready), 32'd0);
            if (cpu_resp_valid && obs_lat == 0) obs_lat = k;
        end
        if (!wr) chk(cpu_resp_rdata == exp_rd, hit ? "R3" : "R9", cpu_resp_rdata, exp_rd);
        chk(wb_cnt == (wbexp ? LW : 0), wbexp ? "R6" : "R9", 32'(wb_cnt), 32'(wbexp ? LW : 0));
        chk(rd_cnt == (hit ? 0 : LW), hit ? "R4" : "R5", 32'(rd_cnt), 32'(hit ? 0 : LW));
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", checks, 0);
        summary();
        $finish;
    end

    initial begin
        int ol;
        logic [15:0] lf = 16'hACE1;
        for (int s = 0; s < NS; s++) begin
            front[s] = -1;
            back[s]  = -1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs while in reset
        chk(cpu_req_ready == 1'b1, "R1", 32'(cpu_req_ready), 32'd1);
        chk(cpu_resp_valid == 1'b0, "R1", 32'(cpu_resp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;

        // R7: line numbers 0, 8, 0, 6, 8 in one set; R1 first access misses
        for (int i = 0; i < 5; i++) begin
            access(1'b0, seq[i] * LINE_BYTES, '0, ol);
            chk((ol == LAT_HIT) == seq_hit[i], "R7", 32'(ol), 32'(seq_hit[i] ? LAT_HIT : LAT_CLEAN));
        end

        // R4: write hit to word 1 of line 8, then R2: read it with nonzero byte bits
        access(1'b1, 8 * LINE_BYTES + 4, 32'hCAFE_0001, ol);
        chk(ol == LAT_HIT, "R4", 32'(ol), 32'(LAT_HIT));
        access(1'b0, 8 * LINE_BYTES + 7, '0, ol);
        chk(ol == LAT_HIT, "R2", 32'(ol), 32'(LAT_HIT));
        access(1'b0, 8 * LINE_BYTES, '0, ol);

        // R6: line 0 replaces clean line 6, then line 2 evicts dirty line 8
        access(1'b0, 0, '0, ol);
        access(1'b0, 2 * LINE_BYTES, '0, ol);
        chk(ol == LAT_DIRTY, "R6", 32'(ol), 32'(LAT_DIRTY));

        // R8: write miss to line 5, read back both words, then force its eviction
        access(1'b1, 5 * LINE_BYTES, 32'h1234_5678, ol);
        chk(ol == LAT_CLEAN, "R8", 32'(ol), 32'(LAT_CLEAN));
        access(1'b0, 5 * LINE_BYTES, '0, ol);
        access(1'b0, 5 * LINE_BYTES + 4, '0, ol);
        access(1'b0, 7 * LINE_BYTES, '0, ol);
        access(1'b0, 9 * LINE_BYTES, '0, ol);
        chk(ol == LAT_DIRTY, "R8", 32'(ol), 32'(LAT_DIRTY));

        // R2 R3 R7 R8 R9: pseudo-random mix over twelve lines
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(lf[5], (int'(lf[3:0]) % 12) * LINE_BYTES + int'(lf[4]) * 4, {lf, ~lf}, ol);
        end

        summary();
        $finish;
    end
endmodule